// File: doc/BRIEF.md
# Programmable Real-Time Clock with Overflow Flag

This block keeps a 16-bit tick counter that advances at a fixed rate while the clock is switched on. A prescaler divides the system clock down to the configured ticks-per-second rate, 1000 by default. Each tick adds one to the counter. When an increment takes the counter from its all-ones value back to zero, a sticky overflow flag is set. The flag is ANDed with an interrupt-enable input to form the interrupt request.

The processor drives the block with single-cycle function-out commands. Each command carries three independent bits: start, stop and clear-flag. The processor tests the flag with a skip-style sense. It can also load the counter directly and read it at any time. Starting a clock that is already running leaves the tick phase alone. A command that carries both stop and start applies stop first and then start, so the clock ends up running with a fresh prescaler phase.

Top module: `rtc_timer`

## Requirements
- R1: A synchronous active-low reset clears the counter to 0 and the overflow flag to 0, and leaves the clock stopped (`run_o` = 0).
- R2: While running, the counter increases by one every DIV = CLK_HZ / TICKS_PER_SEC clock cycles. The first increment comes DIV cycles after the edge that applies a start from the stopped state.
- R3: The counter wraps modulo 2^16. The flag is set only when a tick increment produces 0. Loading 0 does not set it.
- R4: `fo_op[2]` (stop) halts ticking, and the counter then holds its value.
- R5: `fo_op[1]` (start) starts a stopped clock. Issued to a running clock, it does not disturb the tick phase.
- R6: With stop and start in the same command, the clock ends running and the prescaler phase restarts from zero.
- R7: `fo_op[0]` (clear) clears the flag. If a wrap happens in the same cycle, the flag stays set.
- R8: `sense_hit` is 1 exactly when `sense_sel` is 1 and the flag is set.
- R9: `irq` is 1 exactly when the flag is set and `int_en` is 1.
- R10: `ld_en` writes `ld_data` into the counter on the next edge. A load wins over a tick in the same cycle.
- R11: `cnt_o` always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fo_valid | input | 1 | Function-out command strobe |
| fo_op | input | 3 | Command bits: [2] stop, [1] start, [0] clear flag |
| sense_sel | input | 1 | Sense selects the overflow flag |
| int_en | input | 1 | Interrupt enable |
| ld_en | input | 1 | Counter load strobe |
| ld_data | input | 16 | Counter load value |
| cnt_o | output | 16 | Current counter value |
| ovf_o | output | 1 | Overflow flag |
| run_o | output | 1 | Clock running |
| sense_hit | output | 1 | Sense result |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same edge, and each pair is tested.

The first pair is a clear-flag command and the tick that wraps the counter. The bench times the clear so it arrives exactly DIV cycles after the start. It then expects the flag to remain set with the counter at zero.

The second pair is a load and a tick. The bench expects the loaded value, not that value plus one.

The bench also places a redundant start and a combined stop-and-start mid-period. It judges each by the cycle in which the next increment appears.

// File: rtl/rtc_pkg.sv
// Shared command layout for the real-time clock.
// Assumes a 3-bit function-out operand with independent bits.
package rtc_pkg;
    localparam int FO_W    = 3;
    localparam int FO_CLR  = 0;
    localparam int FO_ON   = 1;
    localparam int FO_OFF  = 2;

    typedef struct packed {
        logic stop;
        logic start;
        logic clr;
    } fo_cmd_t;
endpackage

// File: rtl/rtc_run_ctrl.sv
// Run/stop control: decodes function-out commands into the run state,
// a prescaler restart pulse and a flag-clear pulse.
// Assumes fo_valid is a single-cycle strobe. Stop is applied before start.
module rtc_run_ctrl
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fo_valid,
    input  logic [FO_W-1:0] fo_op,
    output logic            run_q,
    output logic            restart,
    output logic            clr_ov
);
    fo_cmd_t cmd;
    logic    after_stop;

    // Unpack the operand and work out the state once stop has been applied.
    always_comb begin
        cmd        = fo_cmd_t'(fo_op);
        after_stop = run_q & ~(fo_valid & cmd.stop);
        restart    = fo_valid & cmd.start & ~after_stop;
        clr_ov     = fo_valid & cmd.clr;
    end

    // Run state register.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (fo_valid) run_q <= after_stop | cmd.start;
    end

    // R4
    stop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_valid && fo_op[FO_OFF] && !fo_op[FO_ON]) |=> !run_q);
    // R5
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_valid && fo_op[FO_ON]) |=> run_q);
endmodule

// File: rtl/rtc_prescaler.sv
// Tick prescaler: emits a one-cycle tick every DIV cycles while run is high.
// Its phase returns to zero when stopped or on a restart pulse.
// Assumes DIV >= 2.
module rtc_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Tick fires on the last phase of each period.
    always_comb tick = run & (phase_q == LAST);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) phase_q <= '0;
        else if (phase_q == LAST)      phase_q <= '0;
        else                           phase_q <= phase_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R6
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
endmodule

// File: rtl/rtc_counter.sv
// Tick counter with a sticky overflow flag.
// Load beats tick. A wrap sets the flag and beats a clear.
module rtc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         clr_ov,
    output logic [W-1:0] cnt_q,
    output logic         ovf_q
);
    logic wrap;

    // A wrap is a tick increment taking the all-ones value to zero.
    always_comb wrap = tick & ~load & (cnt_q == '1);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= ld_data;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Overflow flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovf_q <= 1'b0;
        else if (wrap)   ovf_q <= 1'b1;
        else if (clr_ov) ovf_q <= 1'b0;
    end

    // R3
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q == '1) |=> (ovf_q && cnt_q == '0));
    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(ld_data));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ov && !(tick && !load && cnt_q == '1)) |=> !ovf_q);
endmodule

// File: rtl/rtc_timer.sv
// Real-time clock top: run control, prescaler and counter, plus sense and
// interrupt gating. Assumes CLK_HZ is a multiple of TICKS_PER_SEC with a
// ratio of at least 2.
module rtc_timer
    import rtc_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int TICKS_PER_SEC = 1000,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fo_valid,
    input  logic [FO_W-1:0]  fo_op,
    input  logic             sense_sel,
    input  logic             int_en,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             run_o,
    output logic             sense_hit,
    output logic             irq
);
    localparam int DIV = CLK_HZ / TICKS_PER_SEC;

    logic run_q, restart, clr_ov, tick;

    rtc_run_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fo_valid(fo_valid), .fo_op(fo_op),
        .run_q(run_q), .restart(restart), .clr_ov(clr_ov)
    );

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(restart), .tick(tick)
    );

    rtc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(ld_en), .ld_data(ld_data),
        .clr_ov(clr_ov), .cnt_q(cnt_o), .ovf_q(ovf_o)
    );

    // Output gating for run state, sense and interrupt.
    always_comb begin
        run_o     = run_q;
        sense_hit = sense_sel & ovf_o;
        irq       = ovf_o & int_en;
    end

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !ld_en) |=> $stable(cnt_o));
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(fo_valid && fo_op[FO_CLR])) |=> ovf_o);
endmodule

// File: tb/rtc_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_timer_tb_top;
    localparam int CLK_HZ = 8000;
    localparam int TPS    = 1000;
    localparam int DIV    = CLK_HZ / TPS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fo_valid = 1'b0;
    logic [2:0]  fo_op = 3'b000;
    logic        sense_sel = 1'b0;
    logic        int_en = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_data = 16'h0;
    logic [15:0] cnt_o;
    logic        ovf_o, run_o, sense_hit, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_timer #(.CLK_HZ(CLK_HZ), .TICKS_PER_SEC(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .fo_valid(fo_valid), .fo_op(fo_op),
        .sense_sel(sense_sel), .int_en(int_en), .ld_en(ld_en), .ld_data(ld_data),
        .cnt_o(cnt_o), .ovf_o(ovf_o), .run_o(run_o), .sense_hit(sense_hit), .irq(irq)
    );

    // Vector fields: start[40:25], tick count[24:17], expected count[16:1], expected flag[0]
    localparam logic [40:0] VEC [0:5] = '{
        {16'h0000, 8'd3, 16'h0003, 1'b0},
        {16'hFFFE, 8'd1, 16'hFFFF, 1'b0},
        {16'hFFFE, 8'd2, 16'h0000, 1'b1},
        {16'hFFFF, 8'd3, 16'h0002, 1'b1},
        {16'h1234, 8'd5, 16'h1239, 1'b0},
        {16'h7FFF, 8'd1, 16'h8000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fo(input logic [2:0] op);
        @(negedge clk); fo_valid = 1'b1; fo_op = op;
        @(posedge clk);
        @(negedge clk); fo_valid = 1'b0; fo_op = 3'b000;
    endtask

    task automatic ld(input logic [15:0] v);
        @(negedge clk); ld_en = 1'b1; ld_data = v;
        @(posedge clk);
        @(negedge clk); ld_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset count", 32'(cnt_o), 0);
        chk("R1 reset flag", 32'(ovf_o), 0);
        chk("R1 reset run", 32'(run_o), 0);
        rst_n = 1'b1;
        // R11 stopped clock holds a loaded value
        ld(16'h0005);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R11 stopped hold", 32'(cnt_o), 32'h5);

        // Table walk: R2 rate, R3 wrap and flag
        for (int i = 0; i < 6; i++) begin
            fo(3'b001);
            ld(VEC[i][40:25]);
            fo(3'b010);
            repeat (DIV * int'(VEC[i][24:17])) @(posedge clk);
            @(negedge clk);
            chk("R2 count", 32'(cnt_o), 32'(VEC[i][16:1]));
            chk("R3 flag", 32'(ovf_o), 32'(VEC[i][0]));
            fo(3'b100);
        end

        // R4 stop halts counting
        chk("R4 stopped", 32'(run_o), 0);
        ld(16'h0040);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R4 hold", 32'(cnt_o), 32'h40);

        // R5 redundant start keeps phase
        fo(3'b010);
        repeat (5) @(posedge clk);
        fo(3'b010);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R5 phase kept", 32'(cnt_o), 32'h41);
        fo(3'b100);

        // R6 stop+start restarts phase, stays running
        ld(16'h0080);
        fo(3'b010);
        repeat (5) @(posedge clk);
        fo(3'b110);
        chk("R6 running", 32'(run_o), 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 no early tick", 32'(cnt_o), 32'h80);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R6 tick after restart", 32'(cnt_o), 32'h81);
        fo(3'b100);

        // R3 loading zero does not set flag
        fo(3'b001);
        ld(16'h0000);
        chk("R3 load zero no flag", 32'(ovf_o), 0);

        // Make a wrap, then R8 and R9
        ld(16'hFFFF);
        fo(3'b010);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        fo(3'b100);
        chk("R3 wrap flag", 32'(ovf_o), 1);
        sense_sel = 1'b1; int_en = 1'b0;
        #1;
        chk("R8 sense selected", 32'(sense_hit), 1);
        chk("R9 irq disabled", 32'(irq), 0);
        sense_sel = 1'b0; int_en = 1'b1;
        #1;
        chk("R8 sense unselected", 32'(sense_hit), 0);
        chk("R9 irq enabled", 32'(irq), 1);
        fo(3'b001);
        chk("R7 clear", 32'(ovf_o), 0);
        chk("R9 irq after clear", 32'(irq), 0);

        // R7 clear arriving with a wrap: flag stays set
        ld(16'hFFFF);
        fo(3'b010);
        repeat (DIV - 1) @(posedge clk);
        fo(3'b001);
        chk("R7 wrap beats clear", 32'(ovf_o), 1);
        chk("R7 wrap count", 32'(cnt_o), 0);
        fo(3'b001);
        chk("R7 later clear", 32'(ovf_o), 0);

        // R10 load arriving with a tick: load wins
        repeat (DIV - 3) @(posedge clk);
        ld(16'h0100);
        chk("R10 load beats tick", 32'(cnt_o), 32'h100);
        fo(3'b100);

        // R1 reset while running with flag set
        ld(16'hFFFF);
        fo(3'b010);
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset count", 32'(cnt_o), 0);
        chk("R1 mid reset flag", 32'(ovf_o), 0);
        chk("R1 mid reset run", 32'(run_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule